// File: doc/BRIEF.md
# Slice Storage Element Group

This block is a cycle-based model of the storage elements found in one logic slice. The slice has `LANES` primary elements and `LANES` secondary elements. The whole model runs on a single system clock. The slice's own clock or gate arrives as an ordinary data input, `slice_clk`, and the model samples it on every system clock edge. It finds effective clock edges and gate levels from those samples. Because of this, the model contains no real latches and no asynchronous logic. "Asynchronous" set/reset means the set/reset takes effect at the next system clock edge, without waiting for an effective slice-clock edge.

Some configuration is shared by the whole slice:
- flip-flop or latch mode,
- synchronous or asynchronous set/reset,
- clock polarity,
- whether the clock-enable pin is used,
- whether the set/reset pin is used.

Each element has its own global-init value bit and its own set/reset value bit. Each secondary element chooses its data through a one-hot two-way select, between the companion LUT's second output and the lane's external bypass input. A global-init pulse loads every usable element with its init value.

The polarity-related bits change meaning with the mode:
- In flip-flop mode, clock-invert = 1 inverts the clock, and the init bit loads the complement of its value.
- In latch mode, clock-invert = 0 inverts the gate, and the init bit loads its own value.

Top module: `slice_store`

## Requirements
- R1: While `rst` is high, every bit of `q_pri` and `q_sec` is 0 at the next system clock edge.
- R2: In flip-flop mode, an element loads its data only on a rising edge of the effective clock, with clock enable active. Otherwise it holds its value. The effective clock is `slice_clk` XOR the invert control.
- R3: The invert control depends on the mode. In flip-flop mode it equals `cfg_clkinv`, so with `cfg_clkinv`=1 capture happens on the falling edge of `slice_clk`. In latch mode it equals NOT `cfg_clkinv`, so with `cfg_clkinv`=0 the latch is open while `slice_clk` is low.
- R4: While `ginit` is high, each usable element loads its init value. In flip-flop mode the init value is NOT zini. In latch mode it is zini.
- R5: When set/reset acts on an element, the element loads NOT zrst. So zrst=1 gives 0 and zrst=0 gives 1.
- R6: With `cfg_sync`=1 in flip-flop mode, set/reset acts only on an effective clock edge. With `cfg_sync`=0, or in latch mode, it acts on the next system clock edge regardless of the slice clock.
- R7: With `cfg_ce_used`=0, clock enable is treated as 1 and `slice_ce` is ignored. With `cfg_ce_used`=1, `slice_ce`=0 blocks loading.
- R8: With `cfg_sr_used`=0, `slice_sr` has no effect. With `cfg_sr_used`=1, `slice_sr` drives set/reset.
- R9: In latch mode, a primary element follows its data while the effective gate is high and clock enable is active. It holds while the gate is low.
- R10: In latch mode the secondary elements are unusable. They read 0 and ignore global init, set/reset and data.
- R11: For lane i, the secondary select is `cfg_dsel_sec[2i+1:2i]`. Value 2'b01 selects `o5_sec[i]`. Value 2'b10 selects `x_sec[i]`. Value 2'b00 or 2'b11 is illegal and feeds 0.
- R12: Priority is global init, then set/reset, then enabled data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_latch | input | 1 | Slice-wide latch mode |
| cfg_sync | input | 1 | Slice-wide synchronous set/reset |
| cfg_clkinv | input | 1 | Slice-wide clock/gate invert control |
| cfg_ce_used | input | 1 | Use `slice_ce` (else enable tied 1) |
| cfg_sr_used | input | 1 | Use `slice_sr` (else tied inactive) |
| cfg_zini_pri | input | LANES | Init bit per primary element |
| cfg_zrst_pri | input | LANES | Set/reset value bit per primary element |
| cfg_zini_sec | input | LANES | Init bit per secondary element |
| cfg_zrst_sec | input | LANES | Set/reset value bit per secondary element |
| cfg_dsel_sec | input | 2*LANES | One-hot data select per secondary lane |
| slice_clk | input | 1 | Slice clock or gate, sampled |
| slice_ce | input | 1 | Slice clock enable |
| slice_sr | input | 1 | Slice set/reset |
| ginit | input | 1 | Global init pulse |
| d_pri | input | LANES | Primary element data |
| o5_sec | input | LANES | Companion LUT second output per lane |
| x_sec | input | LANES | External bypass input per lane |
| q_pri | output | LANES | Primary element outputs |
| q_sec | output | LANES | Secondary element outputs |

## Verification
The bench builds the block with the default `LANES`=4. This is enough to give each lane a different init, set/reset and select setting in the same test, so one check can tell lane-to-lane mix-ups apart from value inversions. With four lanes, all four secondary select codes (legal and illegal) fit into a single capture. Every combination of mode and invert setting is driven, so both meanings of the clock-invert and init bits are covered.

// File: rtl/slice_store_pkg.sv
package slice_store_pkg;

  typedef struct packed {
    logic latch;
    logic sync;
    logic clkinv;
    logic ce_used;
    logic sr_used;
  } slice_mode_t;

  // Value loaded on global init: meaning of the bit flips with the mode.
  function automatic logic init_value(input logic latch, input logic zini);
    return latch ? zini : ~zini;
  endfunction

endpackage

// File: rtl/slice_clk_ctrl.sv
module slice_clk_ctrl
  import slice_store_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  slice_mode_t mode,
  input  logic        slice_clk,
  input  logic        slice_ce,
  input  logic        slice_sr,
  output logic        eff_rise,
  output logic        eff_level,
  output logic        ce_eff,
  output logic        sr_eff,
  output logic        sr_async
);

  logic invert;
  logic eff_prev;

  // Latch mode passes the gate when the invert bit is 1.
  assign invert    = mode.latch ? ~mode.clkinv : mode.clkinv;
  assign eff_level = slice_clk ^ invert;

  always_ff @(posedge clk) begin
    if (rst) eff_prev <= 1'b1;  // no spurious edge out of reset
    else     eff_prev <= eff_level;
  end

  assign eff_rise = eff_level & ~eff_prev;
  assign ce_eff   = mode.ce_used ? slice_ce : 1'b1;
  assign sr_eff   = mode.sr_used ? slice_sr : 1'b0;
  assign sr_async = mode.latch | ~mode.sync;

endmodule

// File: rtl/slice_dsel.sv
module slice_dsel (
  input  logic [1:0] sel,
  input  logic       o5_in,
  input  logic       x_in,
  output logic       d_out
);

  always_comb begin
    case (sel)
      2'b01:   d_out = o5_in;
      2'b10:   d_out = x_in;
      default: d_out = 1'b0;  // none or both bits set
    endcase
  end

endmodule

// File: rtl/slice_elem.sv
module slice_elem
  import slice_store_pkg::*;
#(
  parameter bit SECONDARY = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  slice_mode_t mode,
  input  logic        eff_rise,
  input  logic        eff_level,
  input  logic        ce_eff,
  input  logic        sr_eff,
  input  logic        sr_async,
  input  logic        ginit,
  input  logic        zini,
  input  logic        zrst,
  input  logic        d,
  output logic        q
);

  logic usable;
  logic sr_hit;

  assign usable = ~(SECONDARY && mode.latch);
  assign sr_hit = sr_eff & (sr_async | eff_rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (!usable) begin
      q <= 1'b0;
    end else if (ginit) begin
      q <= init_value(mode.latch, zini);
    end else if (sr_hit) begin
      q <= ~zrst;
    end else if (mode.latch) begin
      if (eff_level && ce_eff) q <= d;
    end else if (eff_rise && ce_eff) begin
      q <= d;
    end
  end

  // R4 / R12: global init wins over everything else
  assert_init_load_R4: assert property (@(posedge clk) disable iff (rst)
    (usable && ginit) |=> q == init_value($past(mode.latch), $past(zini)));

  // R6: asynchronous set/reset needs no slice-clock edge
  assert_async_sr_R6: assert property (@(posedge clk) disable iff (rst)
    (usable && !ginit && sr_eff && sr_async) |=> q == !$past(zrst));

  // R2: flip-flop holds without an effective edge
  assert_ff_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (usable && !ginit && !sr_eff && !mode.latch && !eff_rise) |=> q == $past(q));

endmodule

// File: rtl/slice_store.sv
module slice_store
  import slice_store_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_latch,
  input  logic               cfg_sync,
  input  logic               cfg_clkinv,
  input  logic               cfg_ce_used,
  input  logic               cfg_sr_used,
  input  logic [LANES-1:0]   cfg_zini_pri,
  input  logic [LANES-1:0]   cfg_zrst_pri,
  input  logic [LANES-1:0]   cfg_zini_sec,
  input  logic [LANES-1:0]   cfg_zrst_sec,
  input  logic [2*LANES-1:0] cfg_dsel_sec,
  input  logic               slice_clk,
  input  logic               slice_ce,
  input  logic               slice_sr,
  input  logic               ginit,
  input  logic [LANES-1:0]   d_pri,
  input  logic [LANES-1:0]   o5_sec,
  input  logic [LANES-1:0]   x_sec,
  output logic [LANES-1:0]   q_pri,
  output logic [LANES-1:0]   q_sec
);

  localparam int SEL_W = 2;

  slice_mode_t      mode;
  logic             eff_rise, eff_level, ce_eff, sr_eff, sr_async;
  logic [LANES-1:0] d_sec;

  assign mode = '{latch: cfg_latch, sync: cfg_sync, clkinv: cfg_clkinv,
                  ce_used: cfg_ce_used, sr_used: cfg_sr_used};

  slice_clk_ctrl u_clk (
    .clk(clk), .rst(rst), .mode(mode),
    .slice_clk(slice_clk), .slice_ce(slice_ce), .slice_sr(slice_sr),
    .eff_rise(eff_rise), .eff_level(eff_level),
    .ce_eff(ce_eff), .sr_eff(sr_eff), .sr_async(sr_async)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    slice_dsel u_sel (
      .sel(cfg_dsel_sec[SEL_W*i +: SEL_W]),
      .o5_in(o5_sec[i]), .x_in(x_sec[i]), .d_out(d_sec[i])
    );

    slice_elem #(.SECONDARY(1'b0)) u_pri (
      .clk(clk), .rst(rst), .mode(mode),
      .eff_rise(eff_rise), .eff_level(eff_level), .ce_eff(ce_eff),
      .sr_eff(sr_eff), .sr_async(sr_async), .ginit(ginit),
      .zini(cfg_zini_pri[i]), .zrst(cfg_zrst_pri[i]),
      .d(d_pri[i]), .q(q_pri[i])
    );

    slice_elem #(.SECONDARY(1'b1)) u_sec (
      .clk(clk), .rst(rst), .mode(mode),
      .eff_rise(eff_rise), .eff_level(eff_level), .ce_eff(ce_eff),
      .sr_eff(sr_eff), .sr_async(sr_async), .ginit(ginit),
      .zini(cfg_zini_sec[i]), .zrst(cfg_zrst_sec[i]),
      .d(d_sec[i]), .q(q_sec[i])
    );
  end

  // R10: secondaries read zero in latch mode
  assert_sec_unusable_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_latch |=> q_sec == '0);

  // R1: reset clears every output
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (q_pri == '0 && q_sec == '0));

endmodule

// File: tb/slice_store_tb_top.sv
module slice_store_tb_top;

  localparam int L = 4;

  logic clk = 1'b0;
  logic rst;
  logic cfg_latch, cfg_sync, cfg_clkinv, cfg_ce_used, cfg_sr_used;
  logic [L-1:0] cfg_zini_pri, cfg_zrst_pri, cfg_zini_sec, cfg_zrst_sec;
  logic [2*L-1:0] cfg_dsel_sec;
  logic slice_clk, slice_ce, slice_sr, ginit;
  logic [L-1:0] d_pri, o5_sec, x_sec, q_pri, q_sec;

  int checks = 0;
  int errors = 0;
  logic [L-1:0] base;

  always #4 clk = ~clk;  // 125 MHz

  slice_store #(.LANES(L)) dut_i (.*);

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic edge_up();  // raw slice clock low then high
    slice_clk = 1'b0; step();
    slice_clk = 1'b1; step();
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); step();
    chk("R1 q_pri", q_pri, '0);
    chk("R1 q_sec", q_sec, '0);
    rst = 1'b0;
  endtask

  task automatic t_ff_capture();
    cfg_latch = 0; cfg_clkinv = 0; cfg_ce_used = 0; cfg_sr_used = 0;
    slice_clk = 0; step(); step();
    d_pri = 4'hA; cfg_dsel_sec = 8'b01010101; o5_sec = 4'h5; x_sec = 4'h3;
    slice_clk = 1; step();
    chk("R2 capture pri", q_pri, 4'hA);
    chk("R11 o5 sel", q_sec, 4'h5);
    d_pri = 4'h3; step();
    chk("R2 hold high", q_pri, 4'hA);
    slice_clk = 0; step();
    chk("R2 hold fall", q_pri, 4'hA);
  endtask

  task automatic t_ff_invert();
    cfg_clkinv = 1; slice_clk = 1; step(); step();
    d_pri = 4'h6; cfg_dsel_sec = 8'b10101010; x_sec = 4'h3;
    slice_clk = 0; step();
    chk("R3 falling capture", q_pri, 4'h6);
    chk("R11 x sel", q_sec, 4'h3);
    d_pri = 4'h9; slice_clk = 1; step();
    chk("R3 rising ignored", q_pri, 4'h6);
  endtask

  task automatic t_ce();
    cfg_clkinv = 0; cfg_ce_used = 1; slice_ce = 0; slice_clk = 0; step(); step();
    base = q_pri;
    d_pri = ~base; slice_clk = 1; step();
    chk("R7 ce blocks", q_pri, base);
    d_pri = 4'hF; slice_ce = 1; edge_up();
    chk("R7 ce enables", q_pri, 4'hF);
    cfg_ce_used = 0; slice_ce = 0; d_pri = 4'h1; edge_up();
    chk("R7 ce tied one", q_pri, 4'h1);
  endtask

  task automatic t_sr();
    cfg_sync = 0; cfg_sr_used = 1; slice_sr = 0;
    cfg_zrst_pri = 4'b0101; cfg_zrst_sec = 4'b0011;
    slice_clk = 0; step();
    slice_sr = 1; step();
    chk("R6 async pri", q_pri, 4'b1010);
    chk("R5 async sec", q_sec, 4'b1100);
    slice_sr = 0; cfg_sync = 1; d_pri = 4'hF; o5_sec = 4'hF;
    cfg_dsel_sec = 8'b01010101; edge_up();
    chk("R2 reload", q_pri, 4'hF);
    slice_sr = 1; step();
    chk("R6 sync no edge", q_pri, 4'hF);
    chk("R6 sync no edge sec", q_sec, 4'hF);
    edge_up();
    chk("R12 sr over data", q_pri, 4'b1010);
    chk("R5 sync sec", q_sec, 4'b1100);
  endtask

  task automatic t_sr_unused();
    cfg_sync = 0; cfg_sr_used = 0; slice_sr = 1; d_pri = 4'h5;
    slice_clk = 0; step();
    chk("R8 no async effect", q_pri, 4'b1010);
    slice_clk = 1; step();
    chk("R8 data wins", q_pri, 4'h5);
  endtask

  task automatic t_ginit();
    cfg_sr_used = 1; slice_sr = 1;
    cfg_zini_pri = 4'b0011; cfg_zini_sec = 4'b0110;
    ginit = 1; step();
    chk("R4 ff init pri", q_pri, 4'b1100);
    chk("R12 init over sr", q_sec, 4'b1001);
    ginit = 0; step();
    chk("R5 after init", q_pri, 4'b1010);
    slice_sr = 0; cfg_sr_used = 0;
  endtask

  task automatic t_latch();
    cfg_latch = 1; cfg_clkinv = 1; slice_clk = 1; d_pri = 4'hA; step();
    chk("R9 transparent", q_pri, 4'hA);
    chk("R10 sec zero", q_sec, 4'h0);
    d_pri = 4'hC; step();
    chk("R9 follows", q_pri, 4'hC);
    slice_clk = 0; d_pri = 4'h3; step();
    chk("R9 holds", q_pri, 4'hC);
    ginit = 1; step(); ginit = 0;
    chk("R4 latch init", q_pri, 4'b0011);
    chk("R10 ignores init", q_sec, 4'h0);
  endtask

  task automatic t_latch_invert();
    cfg_clkinv = 0; slice_clk = 0; d_pri = 4'h7; step();
    chk("R3 low gate open", q_pri, 4'h7);
    slice_clk = 1; d_pri = 4'h2; step();
    chk("R3 high gate closed", q_pri, 4'h7);
    cfg_sync = 1; cfg_sr_used = 1; slice_sr = 1; step();
    chk("R6 latch sr async", q_pri, 4'b1010);
    slice_sr = 0; cfg_sr_used = 0;
  endtask

  task automatic t_dsel_illegal();
    cfg_latch = 0; cfg_clkinv = 0; slice_clk = 0; step(); step();
    cfg_dsel_sec = 8'b10_01_11_00; o5_sec = 4'b0111; x_sec = 4'b1011;
    slice_clk = 1; step();
    chk("R11 illegal zero", q_sec, 4'b1100);
  endtask

  initial begin
    rst = 1; cfg_latch = 0; cfg_sync = 0; cfg_clkinv = 0; cfg_ce_used = 0;
    cfg_sr_used = 0; cfg_zini_pri = '0; cfg_zrst_pri = '0; cfg_zini_sec = '0;
    cfg_zrst_sec = '0; cfg_dsel_sec = '0; slice_clk = 0; slice_ce = 0;
    slice_sr = 0; ginit = 0; d_pri = '0; o5_sec = '0; x_sec = '0;
    t_reset();
    t_ff_capture();
    t_ff_invert();
    t_ce();
    t_sr();
    t_sr_unused();
    t_ginit();
    t_latch();
    t_latch_invert();
    t_dsel_illegal();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule